// File: doc/BRIEF.md
# Serial Input Transition Detector

This block sits behind a serial input expander that refreshes a wide parallel input vector once per shift frame. Each refresh is marked by a single-cycle frame strobe. On each strobe the block compares the fresh capture with the capture from the previous strobe. For every pin it can flag a rising transition, a falling transition, or both, as its own 2-bit event field selects. Flagged transitions are held in per-bank status bytes until software clears them. Any held bit drives one level-high interrupt line.

Pins are grouped into banks of eight. Each bank has one 16-bit event configuration word and one status byte, both reached through a simple register port. Reads are combinational from the address. A write takes effect on the clock edge where `reg_wr` is high. The capture vector carries no back-pressure: the detector accepts every strobe, and `frame_done` is a plain control input with no ready handshake.

Top module: `pin_event_detector`

## Requirements
- R1: After reset, all configuration words and status bytes read 0 and `irq` is low.
- R2: Pin p of bank b is input bit b*8+p. Its event field is bits 2p+1:2p of the bank's configuration word. When field bit 0 is set, a 0-to-1 change of the pin between two frame strobes sets status bit p of bank b on the edge where the second strobe is sampled.
- R3: When field bit 1 is set, a 1-to-0 change between two frame strobes sets that status bit in the same way.
- R4: Field value 11 detects both directions. Field value 00 never sets the status bit.
- R5: The first strobe after reset only records the reference capture and sets no status bit.
- R6: Comparisons happen only on strobe cycles, and each one is against the capture taken at the previous strobe. Input changes between strobes set no status bit by themselves.
- R7: Writing a word to status address 0x20+b clears each bank-b status bit where wdata[7:0] holds a 1. Bits where wdata holds a 0 are left unchanged.
- R8: If a transition for a pin is detected in the same cycle that a write clears that pin's status bit, the bit ends up set.
- R9: `irq` is the OR of all status bits, delayed by one register. It rises one cycle after a bit is set and falls one cycle after the last set bit is cleared.
- R10: The configuration word of bank b sits at address 0x10+2b. Odd addresses in 0x10..0x1F, and any address outside the configuration and status ranges, read 0. Writes to those addresses change nothing.
- R11: A status bit stays set after the pin returns to its former level or stops changing. Only a clear write removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done | input | 1 | Single-cycle strobe: `cap_in` holds a fresh frame |
| cap_in | input | 64 | Captured parallel input vector, bank b in bits b*8+7:b*8 |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Level-high interrupt, registered OR of all status bits |

## Verification
A frame strobe that detects a transition can land in the same cycle as a write that clears that pin's status bit. The two updates then compete for one flop. A directed case raises a transition on two pins while the same edge writes a clear mask that covers them. The result must read back as set. The random phase then mixes strobes, clear writes and configuration writes on many cycles, so the collision recurs on many pins. After every cycle a bench model, which applies the clear first and the set second, judges the interrupt line. Every few cycles it also judges every register.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;
  localparam int unsigned PEV_BANKS      = 8;
  localparam int unsigned PEV_BANK_PINS  = 8;
  localparam int unsigned PEV_ADDR_W     = 6;
  localparam int unsigned PEV_CFG_BASE   = 'h10;
  localparam int unsigned PEV_STAT_BASE  = 'h20;

  // 2-bit per-pin event selector
  typedef enum logic [1:0] {
    EV_OFF  = 2'b00,
    EV_RISE = 2'b01,
    EV_FALL = 2'b10,
    EV_BOTH = 2'b11
  } ev_sel_e;

  function automatic int unsigned cfg_addr_of(input int unsigned bank);
    return PEV_CFG_BASE + 2 * bank;
  endfunction

  function automatic int unsigned stat_addr_of(input int unsigned bank);
    return PEV_STAT_BASE + bank;
  endfunction
endpackage

// File: rtl/pin_event_frame_ref.sv
// Holds the capture of the previous frame and reports per-pin transitions
// on each strobe once a reference exists.
module pin_event_frame_ref #(
  parameter int unsigned N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_done,
  input  logic [N-1:0] cap_in,
  output logic         cmp_valid,
  output logic [N-1:0] rise_vec,
  output logic [N-1:0] fall_vec
);
  logic [N-1:0] prev_q;
  logic         primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (frame_done) begin
      prev_q   <= cap_in;
      primed_q <= 1'b1;
    end
  end

  assign cmp_valid = frame_done & primed_q;
  assign rise_vec  = cap_in & ~prev_q;
  assign fall_vec  = ~cap_in & prev_q;
endmodule

// File: rtl/pin_event_bank.sv
// One bank: event configuration word and write-one-to-clear status byte.
module pin_event_bank
  import pin_event_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [2*W-1:0] cfg_wdata,
  input  logic           clr_we,
  input  logic [W-1:0]   clr_mask,
  input  logic           cmp_valid,
  input  logic [W-1:0]   rise,
  input  logic [W-1:0]   fall,
  output logic [2*W-1:0] cfg_q,
  output logic [W-1:0]   status_q
);
  logic [W-1:0] evt;
  logic [W-1:0] status_d;

  for (genvar p = 0; p < W; p++) begin : g_pin
    ev_sel_e sel;
    assign sel    = ev_sel_e'(cfg_q[2*p +: 2]);
    assign evt[p] = cmp_valid &
                    ((rise[p] & sel[0]) | (fall[p] & sel[1]));
  end

  // clear first, then set: a same-cycle event wins
  always_comb begin
    status_d = status_q;
    if (clr_we) status_d = status_d & ~clr_mask;
    status_d = status_d | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      status_q <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/pin_event_irq.sv
// Registered reduction of all status bits into one level interrupt.
module pin_event_irq #(
  parameter int unsigned N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] status_all,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |status_all;
  end
endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
  import pin_event_pkg::*;
#(
  parameter int unsigned NUM_BANKS = PEV_BANKS,
  parameter int unsigned BANK_PINS = PEV_BANK_PINS,
  parameter int unsigned ADDR_W    = PEV_ADDR_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           frame_done,
  input  logic [NUM_BANKS*BANK_PINS-1:0] cap_in,
  input  logic                           reg_wr,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [2*BANK_PINS-1:0]         reg_wdata,
  output logic [2*BANK_PINS-1:0]         reg_rdata,
  output logic                           irq
);
  localparam int unsigned NUM_PINS = NUM_BANKS * BANK_PINS;
  localparam int unsigned CFG_W    = 2 * BANK_PINS;

  logic                       cmp_valid;
  logic [NUM_PINS-1:0]        rise_vec;
  logic [NUM_PINS-1:0]        fall_vec;
  logic [NUM_BANKS*CFG_W-1:0] cfg_all;
  logic [NUM_PINS-1:0]        status_all;

  pin_event_frame_ref #(.N(NUM_PINS)) u_ref (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .cap_in     (cap_in),
    .cmp_valid  (cmp_valid),
    .rise_vec   (rise_vec),
    .fall_vec   (fall_vec)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(cfg_addr_of(b));
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(stat_addr_of(b));
    logic cfg_we, clr_we;
    assign cfg_we = reg_wr && (reg_addr == CFG_A);
    assign clr_we = reg_wr && (reg_addr == STAT_A);

    pin_event_bank #(.W(BANK_PINS)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (reg_wdata),
      .clr_we    (clr_we),
      .clr_mask  (reg_wdata[BANK_PINS-1:0]),
      .cmp_valid (cmp_valid),
      .rise      (rise_vec[b*BANK_PINS +: BANK_PINS]),
      .fall      (fall_vec[b*BANK_PINS +: BANK_PINS]),
      .cfg_q     (cfg_all[b*CFG_W +: CFG_W]),
      .status_q  (status_all[b*BANK_PINS +: BANK_PINS])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_addr == ADDR_W'(cfg_addr_of(b)))
        reg_rdata = cfg_all[b*CFG_W +: CFG_W];
      if (reg_addr == ADDR_W'(stat_addr_of(b)))
        reg_rdata = {{(CFG_W-BANK_PINS){1'b0}},
                     status_all[b*BANK_PINS +: BANK_PINS]};
    end
  end

  pin_event_irq #(.N(NUM_PINS)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .status_all (status_all),
    .irq        (irq)
  );
endmodule

// File: rtl/pin_event_checker.sv
module pin_event_checker
  import pin_event_pkg::*;
#(
  parameter int unsigned NUM_BANKS = PEV_BANKS,
  parameter int unsigned BANK_PINS = PEV_BANK_PINS,
  parameter int unsigned ADDR_W    = PEV_ADDR_W
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             frame_done,
  input logic                             reg_wr,
  input logic [ADDR_W-1:0]                reg_addr,
  input logic [2*BANK_PINS-1:0]           reg_wdata,
  input logic [NUM_BANKS*2*BANK_PINS-1:0] cfg_all,
  input logic [NUM_BANKS*BANK_PINS-1:0]   status_all,
  input logic                             irq
);
  logic cfg_hit;
  always_comb begin
    cfg_hit = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (reg_wr && reg_addr == ADDR_W'(cfg_addr_of(b))) cfg_hit = 1'b1;
  end

  // R9: interrupt is the one-cycle-late OR of the status bits
  assert_irq_tracks_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |$past(status_all)));

  // R6: without a strobe no status bit can become set
  assert_no_set_without_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> ((status_all & ~$past(status_all)) == '0));

  // R10: configuration only changes through a write to a configuration address
  assert_cfg_only_by_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hit |=> $stable(cfg_all));

  // R7: a clear write with no strobe leaves the written-one bits cleared
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_clr
    assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(stat_addr_of(b)) && !frame_done) |=>
      ((status_all[b*BANK_PINS +: BANK_PINS] & $past(reg_wdata[BANK_PINS-1:0])) == '0));
  end
endmodule

bind pin_event_detector pin_event_checker #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_PINS (BANK_PINS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_done (frame_done),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .cfg_all    (cfg_all),
  .status_all (status_all),
  .irq        (irq)
);

// File: tb/pin_event_detector_tb.sv
module pin_event_detector_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int NP = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_done = 1'b0;
  logic [63:0] cap_in = '0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] ref_cfg [NB];
  logic [63:0] ref_stat   = '0;
  logic [63:0] ref_prev   = '0;
  bit          ref_primed = 1'b0;
  logic        ref_irq    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_event_detector u_dut (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .cap_in(cap_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(string t, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", t, got, exp);
    end
  endtask

  function automatic logic [15:0] model_read(logic [5:0] a);
    if (a >= 6'h10 && a <= 6'h1F && !a[0]) return ref_cfg[int'(a - 6'h10) / 2];
    if (a >= 6'h20 && a <= 6'h27) begin
      int b = int'(a - 6'h20);
      return {8'h00, ref_stat[b*8 +: 8]};
    end
    return 16'h0000;
  endfunction

  function automatic logic [63:0] model_events(bit fd, logic [63:0] cap);
    logic [63:0] e = '0;
    if (fd && ref_primed)
      for (int p = 0; p < NP; p++) begin
        logic [1:0] f = ref_cfg[p/8][(p%8)*2 +: 2];
        if (f[0] && cap[p] && !ref_prev[p]) e[p] = 1'b1;
        if (f[1] && !cap[p] && ref_prev[p]) e[p] = 1'b1;
      end
    return e;
  endfunction

  // one clock cycle with the given stimulus; model updates and irq is checked
  task automatic step(bit fd, logic [63:0] cap, bit wr, logic [5:0] a,
                      logic [15:0] wd, string t);
    logic [63:0] evt, clr;
    logic        irq_next;
    frame_done = fd; cap_in = cap; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    evt = model_events(fd, cap);
    clr = '0;
    if (wr && a >= 6'h20 && a <= 6'h27) clr[int'(a - 6'h20)*8 +: 8] = wd[7:0];
    irq_next = |ref_stat;
    ref_stat = (ref_stat & ~clr) | evt;
    if (wr && a >= 6'h10 && a <= 6'h1F && !a[0]) ref_cfg[int'(a - 6'h10) / 2] = wd;
    if (fd) begin ref_prev = cap; ref_primed = 1'b1; end
    ref_irq = irq_next;
    @(negedge clk);
    frame_done = 1'b0; reg_wr = 1'b0;
    chk({t, " irq"}, {63'b0, irq}, {63'b0, ref_irq});
  endtask

  task automatic rd(string t, logic [5:0] a, logic [15:0] exp);
    reg_addr = a; #1;
    chk(t, {48'b0, reg_rdata}, {48'b0, exp});
    chk({t, " model"}, {48'b0, reg_rdata}, {48'b0, model_read(a)});
  endtask

  task automatic rd_all(string t);
    for (int b = 0; b < NB; b++) begin
      logic [5:0] a;
      a = 6'h10 + 6'(2*b); reg_addr = a; #1;
      chk(t, {48'b0, reg_rdata}, {48'b0, model_read(a)});
      a = 6'h20 + 6'(b); reg_addr = a; #1;
      chk(t, {48'b0, reg_rdata}, {48'b0, model_read(a)});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] cap;
    void'($urandom(32'd20240611));
    for (int b = 0; b < NB; b++) ref_cfg[b] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {63'b0, irq}, 64'd0);
    rd("R1 cfg0", 6'h10, 16'h0000);
    rd("R1 stat0", 6'h20, 16'h0000);
    rd("R1 stat7", 6'h27, 16'h0000);

    // bank0: pin0 rise, pin1 fall, pin2 both, pin3 off
    step(0, 64'h0, 1, 6'h10, 16'h0039, "cfg");
    rd("R2 cfg readback", 6'h10, 16'h0039);
    // R5 first frame is reference only
    step(1, 64'h0F, 0, 6'h00, 16'h0, "R5");
    rd("R5 no event first frame", 6'h20, 16'h0000);
    // R3 / R4 falling on all four pins
    step(1, 64'h00, 0, 6'h00, 16'h0, "R9 latency");
    rd("R3 R4 falling", 6'h20, 16'h0006);
    chk("R9 irq not yet", {63'b0, irq}, 64'd0);
    step(0, 64'h00, 0, 6'h00, 16'h0, "R9");
    chk("R9 irq raised", {63'b0, irq}, 64'd1);
    // R7 write-one-to-clear
    step(0, 64'h00, 1, 6'h20, 16'h0002, "R7");
    rd("R7 partial clear", 6'h20, 16'h0004);
    step(0, 64'h00, 1, 6'h20, 16'h0004, "R7");
    rd("R7 cleared", 6'h20, 16'h0000);
    chk("R9 irq held one cycle", {63'b0, irq}, 64'd1);
    step(0, 64'h00, 0, 6'h00, 16'h0, "R9");
    chk("R9 irq dropped", {63'b0, irq}, 64'd0);
    // R6 changes between strobes do nothing
    step(0, 64'h0F, 0, 6'h00, 16'h0, "R6");
    step(0, 64'h0F, 0, 6'h00, 16'h0, "R6");
    rd("R6 no strobe no event", 6'h20, 16'h0000);
    step(1, 64'h0F, 0, 6'h00, 16'h0, "R2");
    rd("R2 R4 rising", 6'h20, 16'h0005);
    // R11 sticky
    step(1, 64'h0F, 0, 6'h00, 16'h0, "R11");
    rd("R11 sticky no change", 6'h20, 16'h0005);
    step(1, 64'h00, 0, 6'h00, 16'h0, "R11");
    rd("R11 accumulate", 6'h20, 16'h0007);
    // R8 set wins over clear
    step(0, 64'h00, 1, 6'h20, 16'h00FF, "R8");
    rd("R8 pre-clear", 6'h20, 16'h0000);
    step(1, 64'h0F, 1, 6'h20, 16'h0005, "R8");
    rd("R8 set wins", 6'h20, 16'h0005);
    // R10 map holes ignored
    step(0, 64'h0F, 1, 6'h11, 16'hFFFF, "R10");
    step(0, 64'h0F, 1, 6'h30, 16'hFFFF, "R10");
    rd("R10 odd addr", 6'h11, 16'h0000);
    rd("R10 neighbour cfg", 6'h12, 16'h0000);
    rd("R10 hole addr", 6'h30, 16'h0000);
    // upper banks: bank3 all rise, bank7 pin63 fall only
    step(0, 64'h0F, 1, 6'h16, 16'h5555, "R2");
    step(0, 64'h0F, 1, 6'h1E, 16'h8000, "R3");
    step(1, 64'h80000000_AA00000F, 0, 6'h00, 16'h0, "R2");
    rd("R2 bank3 rising", 6'h23, 16'h00AA);
    rd("R3 rise ignored pin63", 6'h27, 16'h0000);
    step(1, 64'h00000000_AA00000F, 0, 6'h00, 16'h0, "R3");
    rd("R3 bank7 falling", 6'h27, 16'h0080);

    // random phase
    cap = 64'h00000000_AA00000F;
    for (int i = 0; i < 3000; i++) begin
      bit fd, wr;
      logic [5:0] a;
      logic [15:0] wd;
      int kind;
      fd = ($urandom % 2) == 0;
      cap = cap ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      kind = $urandom % 8;
      wr = kind < 6;
      wd = 16'($urandom);
      case (kind)
        0, 1:    a = 6'h10 + 6'(2 * ($urandom % 8));
        2, 3, 4: a = 6'h20 + 6'($urandom % 8);
        default: a = 6'($urandom);
      endcase
      step(fd, cap, wr, a, wd, "random R2 R3 R4 R6 R7 R8 R9");
      if (i % 4 == 0) rd_all("random R10 R11 readback");
    end

    // quiet state: all fields off, all status cleared
    for (int b = 0; b < NB; b++) step(0, cap, 1, 6'h10 + 6'(2*b), 16'h0, "R4 quiet");
    for (int b = 0; b < NB; b++) step(0, cap, 1, 6'h20 + 6'(b), 16'h00FF, "R7 quiet");
    step(1, ~cap, 0, 6'h00, 16'h0, "R4 quiet");
    step(1, cap, 0, 6'h00, 16'h0, "R4 quiet");
    rd_all("R4 off fields quiet");
    chk("R9 quiet irq", {63'b0, irq}, 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule